// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block is a watchdog peripheral on a small 32-bit register bus. A 32-bit up-counter advances on a slow reference tick, either on every tick or through a power-of-two prescaler. When it wraps past all-ones it reloads itself from a programmable load value and raises a one-cycle reset request for an external system reset generator. Firmware keeps the system alive by writing a new value into a trigger register. Each such write reloads the counter from the load value.

The counter runs or halts only after a two-word key sequence has been written to a key register. A stray write cannot stop the watchdog. Writes to the registers that the slow domain uses are posted. A pending bit stays set for a fixed number of core cycles until the write takes effect, and firmware polls it before it relies on the new value. The block also has an early-warning match register, overflow and early-warning interrupt status with separate enables, a self-clearing soft reset and a read-only revision word.

Top module: `keyedWatchdog`

## Requirements
- R1: After reset every register reads zero except the revision word at 0x00. The counter is halted and no interrupt or reset request is active.
- R2: The pending register at 0x14 has one bit per posted register: bit0 control, bit1 load, bit2 trigger, bit3 early-warning match, bit4 key. A posted write sets its bit. The bit reads 1 on the four reads that follow the write, one read per cycle, and 0 from the fifth read on. The new value is visible from that fifth read.
- R3: While running, the counter at 0x20 (read-only) rises by exactly one per prescaled step. While halted it holds its value. Writing the load register at 0x1C does not change the counter.
- R4: Control register at 0x18: bits[2:0] select a divide ratio of 2^n and bit3 enables the prescaler. With bit3 set, the counter steps once every 2^n reference ticks. With bit3 clear, it steps on every tick. A reload restarts the prescaler phase.
- R5: The counter starts only after the key register at 0x2C receives 0x0000BBBB and then 0x00004444.
- R6: The counter halts only after the key register receives 0x0000AAAA and then 0x00005555.
- R7: A second key word that does not complete the open sequence abandons it and leaves the running state unchanged. A lone second key word does nothing. A fresh sequence must begin with a first key word.
- R8: A write to the trigger register at 0x24 reloads the counter from the load value only if the written value differs from the trigger register's current contents.
- R9: A step from 0xFFFFFFFF reloads the counter from the load value, pulses resetReq for exactly one cycle and sets status bit0 of 0x08. The timeout is therefore 2^32 minus the load value in steps.
- R10: A step that lands the counter on the match register value (0x28) sets status bit1 of 0x08.
- R11: Writing 1s to 0x0C sets interrupt enables (bit0 overflow, bit1 early warning). Writing 1s to 0x10 clears them, and both addresses read back the enables. Writing a 1 to a status bit clears it. irqOut is high while any status bit is set together with its enable.
- R12: Writing 1 to bit0 of 0x04 starts a soft reset. The bit reads 1 on the read that follows the write, the block then returns to its R1 state, and the bit reads 0 again.
- R13: regReady is high in the cycle after each read or write. Read data is valid at that time. Reads from unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refTick | input | 1 | One-cycle pulse per slow reference period |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe |
| regAddr | input | ADDR_W | Byte address of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid while regReady is high |
| regReady | output | 1 | Access completion, one cycle after the strobe |
| irqOut | output | 1 | Level interrupt: enabled status bits ORed |
| resetReq | output | 1 | One-cycle pulse on counter overflow |

## Verification
If the key sequencer is in the wrong state, the counter read back at 0x20 stops or keeps moving on the next reference tick. A wrong prescaler phase shows as a count that is off by one step after a known number of ticks. A lost or early posted write shows in the pending register within five reads, and in the register value that is read right after. Overflow faults show in the same cycle on resetReq and one cycle later in the status register and on irqOut. Every check therefore compares a read-back or an output against a count derived from the number of ticks and writes issued.

// File: rtl/keyedWdtPkg.sv
package keyedWdtPkg;

  localparam int CNT_W    = 32;
  localparam int PTV_W    = 3;
  localparam int NUM_SYNC = 5;

  localparam int SLOT_CTRL  = 0;
  localparam int SLOT_LOAD  = 1;
  localparam int SLOT_TRIG  = 2;
  localparam int SLOT_DELAY = 3;
  localparam int SLOT_KEY   = 4;

  localparam logic [7:0] ADR_REV     = 8'h00;
  localparam logic [7:0] ADR_SYSCTL  = 8'h04;
  localparam logic [7:0] ADR_STAT    = 8'h08;
  localparam logic [7:0] ADR_ENSET   = 8'h0C;
  localparam logic [7:0] ADR_ENCLR   = 8'h10;
  localparam logic [7:0] ADR_PEND    = 8'h14;
  localparam logic [7:0] ADR_CTRL    = 8'h18;
  localparam logic [7:0] ADR_LOAD    = 8'h1C;
  localparam logic [7:0] ADR_COUNT   = 8'h20;
  localparam logic [7:0] ADR_TRIG    = 8'h24;
  localparam logic [7:0] ADR_DELAY   = 8'h28;
  localparam logic [7:0] ADR_KEY     = 8'h2C;

  localparam logic [31:0] KEY_HALT_A = 32'h0000_AAAA;
  localparam logic [31:0] KEY_HALT_B = 32'h0000_5555;
  localparam logic [31:0] KEY_RUN_A  = 32'h0000_BBBB;
  localparam logic [31:0] KEY_RUN_B  = 32'h0000_4444;

  typedef enum logic [1:0] {
    KEY_IDLE,
    KEY_HALT_HALF,
    KEY_RUN_HALF
  } keyState_e;

  typedef struct packed {
    logic             clear;
    logic             reload;
    logic             run;
    logic             preEn;
    logic [PTV_W-1:0] ptv;
    logic [CNT_W-1:0] loadVal;
    logic [CNT_W-1:0] delayVal;
  } dpCtl_t;

  function automatic logic [7:0] slotAddr(input int idx);
    case (idx)
      SLOT_CTRL:  return ADR_CTRL;
      SLOT_LOAD:  return ADR_LOAD;
      SLOT_TRIG:  return ADR_TRIG;
      SLOT_DELAY: return ADR_DELAY;
      default:    return ADR_KEY;
    endcase
  endfunction

endpackage

// File: rtl/wdtPendSlot.sv
module wdtPendSlot #(
  parameter int LAT = 4,
  parameter int W   = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         wrStb,
  input  logic [W-1:0] wrData,
  output logic         busy,
  output logic         commit,
  output logic [W-1:0] stagedData
);

  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain     <= '0;
      stagedData <= '0;
    end else if (clr) begin
      remain     <= '0;
      stagedData <= '0;
    end else if (wrStb) begin
      remain     <= CW'(LAT);
      stagedData <= wrData;
    end else if (remain != '0) begin
      remain <= remain - CW'(1);
    end
  end

  assign busy   = (remain != '0);
  assign commit = (remain == CW'(1)) && !wrStb && !clr;

  // R2: a write in flight stays pending until it commits
  p_busy_until_commit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !commit && !clr) |=> busy);

  // R2: the pending flag drops at the commit edge
  p_commit_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> !busy);

endmodule

// File: rtl/wdtCounterPath.sv
module wdtCounterPath
  import keyedWdtPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  dpCtl_t           ctl,
  output logic [CNT_W-1:0] count,
  output logic             ovfPulse,
  output logic             dlyPulse
);

  localparam int DIV_W = (1 << PTV_W) - 1;

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLimit;
  logic             divWrap;
  logic             step;
  logic [CNT_W-1:0] nextCount;

  always_comb begin
    divLimit  = (DIV_W'(1) << ctl.ptv) - DIV_W'(1);
    divWrap   = (divCnt >= divLimit);
    step      = ctl.run && refTick && (!ctl.preEn || divWrap);
    nextCount = count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (ctl.clear || ctl.reload) begin
      divCnt <= '0;
    end else if (ctl.run && refTick && ctl.preEn) begin
      divCnt <= divWrap ? '0 : divCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      ovfPulse <= 1'b0;
      dlyPulse <= 1'b0;
    end else begin
      ovfPulse <= 1'b0;
      dlyPulse <= 1'b0;
      if (ctl.clear) begin
        count <= '0;
      end else if (ctl.reload) begin
        count <= ctl.loadVal;
      end else if (step) begin
        if (count == '1) begin
          count    <= ctl.loadVal;
          ovfPulse <= 1'b1;
        end else begin
          count    <= nextCount;
          dlyPulse <= (nextCount == ctl.delayVal);
        end
      end
    end
  end

  // R3: a halted counter holds its value
  p_hold_when_halted_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.run && !ctl.reload && !ctl.clear) |=> $stable(count));

  // R3: without reload or clear the counter only holds, steps by one, or wraps
  p_single_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.reload && !ctl.clear) |=>
      (count == $past(count) || count == $past(count) + CNT_W'(1) || ovfPulse));

  // R9: an overflow leaves the counter at the load value
  p_ovf_reload_r9: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (count == $past(ctl.loadVal)));

endmodule

// File: rtl/wdtControl.sv
module wdtControl
  import keyedWdtPkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          PEND_LAT = 4,
  parameter logic [31:0] REV_ID   = 32'h0002_0103
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              regReady,
  input  logic [CNT_W-1:0]  counterVal,
  input  logic              ovfPulse,
  input  logic              dlyPulse,
  output dpCtl_t            dpCtl,
  output logic              irqOut
);

  logic             srBusy;
  logic             running;
  keyState_e        keyState;
  logic [PTV_W:0]   ctrlReg;
  logic [CNT_W-1:0] loadReg;
  logic [CNT_W-1:0] trigReg;
  logic [CNT_W-1:0] delayReg;
  logic [1:0]       irqStat;
  logic [1:0]       irqEn;

  logic [NUM_SYNC-1:0] slotWr;
  logic [NUM_SYNC-1:0] slotBusy;
  logic [NUM_SYNC-1:0] slotCommit;
  logic [31:0]         slotData [NUM_SYNC];

  logic        reloadStb;
  logic [1:0]  w1cMask;
  logic        wrSys;
  logic        wrSet;
  logic        wrClr;
  logic [31:0] rdMux;

  for (genvar g = 0; g < NUM_SYNC; g++) begin : gSlot
    assign slotWr[g] = regWr && (regAddr == ADDR_W'(slotAddr(g)));
    wdtPendSlot #(.LAT(PEND_LAT), .W(32)) uSlot (
      .clk       (clk),
      .rstN      (rstN),
      .clr       (srBusy),
      .wrStb     (slotWr[g]),
      .wrData    (regWdata),
      .busy      (slotBusy[g]),
      .commit    (slotCommit[g]),
      .stagedData(slotData[g])
    );
  end

  always_comb begin
    wrSys     = regWr && (regAddr == ADDR_W'(ADR_SYSCTL));
    wrSet     = regWr && (regAddr == ADDR_W'(ADR_ENSET));
    wrClr     = regWr && (regAddr == ADDR_W'(ADR_ENCLR));
    w1cMask   = (regWr && (regAddr == ADDR_W'(ADR_STAT))) ? regWdata[1:0] : 2'b00;
    reloadStb = slotCommit[SLOT_TRIG] && (slotData[SLOT_TRIG] != trigReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       srBusy <= 1'b0;
    else if (srBusy) srBusy <= 1'b0;
    else if (wrSys && regWdata[0]) srBusy <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      keyState <= KEY_IDLE;
      ctrlReg  <= '0;
      loadReg  <= '0;
      trigReg  <= '0;
      delayReg <= '0;
      irqStat  <= '0;
      irqEn    <= '0;
    end else if (srBusy) begin
      running  <= 1'b0;
      keyState <= KEY_IDLE;
      ctrlReg  <= '0;
      loadReg  <= '0;
      trigReg  <= '0;
      delayReg <= '0;
      irqStat  <= '0;
      irqEn    <= '0;
    end else begin
      if (slotCommit[SLOT_CTRL])  ctrlReg  <= slotData[SLOT_CTRL][PTV_W:0];
      if (slotCommit[SLOT_LOAD])  loadReg  <= slotData[SLOT_LOAD];
      if (slotCommit[SLOT_TRIG])  trigReg  <= slotData[SLOT_TRIG];
      if (slotCommit[SLOT_DELAY]) delayReg <= slotData[SLOT_DELAY];
      if (slotCommit[SLOT_KEY]) begin
        case (keyState)
          KEY_IDLE: begin
            if (slotData[SLOT_KEY] == KEY_RUN_A)       keyState <= KEY_RUN_HALF;
            else if (slotData[SLOT_KEY] == KEY_HALT_A) keyState <= KEY_HALT_HALF;
          end
          KEY_RUN_HALF: begin
            if (slotData[SLOT_KEY] == KEY_RUN_B) running <= 1'b1;
            keyState <= KEY_IDLE;
          end
          KEY_HALT_HALF: begin
            if (slotData[SLOT_KEY] == KEY_HALT_B) running <= 1'b0;
            keyState <= KEY_IDLE;
          end
          default: keyState <= KEY_IDLE;
        endcase
      end
      if (wrSet)      irqEn <= irqEn | regWdata[1:0];
      else if (wrClr) irqEn <= irqEn & ~regWdata[1:0];
      irqStat <= (irqStat & ~w1cMask) | {dlyPulse, ovfPulse};
    end
  end

  always_comb begin
    rdMux = '0;
    case (regAddr)
      ADDR_W'(ADR_REV):    rdMux = REV_ID;
      ADDR_W'(ADR_SYSCTL): rdMux = {31'd0, srBusy};
      ADDR_W'(ADR_STAT):   rdMux = {30'd0, irqStat};
      ADDR_W'(ADR_ENSET):  rdMux = {30'd0, irqEn};
      ADDR_W'(ADR_ENCLR):  rdMux = {30'd0, irqEn};
      ADDR_W'(ADR_PEND):   rdMux = 32'(slotBusy);
      ADDR_W'(ADR_CTRL):   rdMux = 32'(ctrlReg);
      ADDR_W'(ADR_LOAD):   rdMux = loadReg;
      ADDR_W'(ADR_COUNT):  rdMux = counterVal;
      ADDR_W'(ADR_TRIG):   rdMux = trigReg;
      ADDR_W'(ADR_DELAY):  rdMux = delayReg;
      default:             rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regReady <= 1'b0;
      regRdata <= '0;
    end else begin
      regReady <= regRd || regWr;
      if (regRd) regRdata <= rdMux;
    end
  end

  assign dpCtl.clear    = srBusy;
  assign dpCtl.reload   = reloadStb;
  assign dpCtl.run      = running;
  assign dpCtl.preEn    = ctrlReg[PTV_W];
  assign dpCtl.ptv      = ctrlReg[PTV_W-1:0];
  assign dpCtl.loadVal  = loadReg;
  assign dpCtl.delayVal = delayReg;

  assign irqOut = |(irqStat & irqEn);

  // R5: the counter only starts from the half-completed run sequence
  p_start_keyed_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> ($past(keyState) == KEY_RUN_HALF));

  // R6: the counter only halts from the half-completed halt sequence or a soft reset
  p_stop_keyed_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> ($past(keyState) == KEY_HALT_HALF || $past(srBusy)));

  // R9: an overflow pulse is latched into the status register
  p_ovf_status_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ovfPulse && !srBusy) |=> irqStat[0]);

  // R12: a soft reset leaves the block halted with defaults
  p_soft_reset_r12: assert property (@(posedge clk) disable iff (!rstN)
    srBusy |=> (!running && irqEn == 2'b00 && loadReg == '0 && !srBusy));

  // R13: every access is acknowledged in the following cycle
  p_ready_r13: assert property (@(posedge clk) disable iff (!rstN)
    (regRd || regWr) |=> regReady);

endmodule

// File: rtl/keyedWatchdog.sv
module keyedWatchdog
  import keyedWdtPkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          PEND_LAT = 4,
  parameter logic [31:0] REV_ID   = 32'h0002_0103
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              regReady,
  output logic              irqOut,
  output logic              resetReq
);

  dpCtl_t           dpCtl;
  logic [CNT_W-1:0] counterVal;
  logic             ovfPulse;
  logic             dlyPulse;

  wdtControl #(
    .ADDR_W  (ADDR_W),
    .PEND_LAT(PEND_LAT),
    .REV_ID  (REV_ID)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regRd     (regRd),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .regReady  (regReady),
    .counterVal(counterVal),
    .ovfPulse  (ovfPulse),
    .dlyPulse  (dlyPulse),
    .dpCtl     (dpCtl),
    .irqOut    (irqOut)
  );

  wdtCounterPath uPath (
    .clk     (clk),
    .rstN    (rstN),
    .refTick (refTick),
    .ctl     (dpCtl),
    .count   (counterVal),
    .ovfPulse(ovfPulse),
    .dlyPulse(dlyPulse)
  );

  assign resetReq = ovfPulse;

endmodule

// File: tb/tb_keyedWatchdog.sv
module tb_keyedWatchdog;

  localparam logic [7:0]  A_REV   = 8'h00;
  localparam logic [7:0]  A_SYS   = 8'h04;
  localparam logic [7:0]  A_STAT  = 8'h08;
  localparam logic [7:0]  A_ENSET = 8'h0C;
  localparam logic [7:0]  A_ENCLR = 8'h10;
  localparam logic [7:0]  A_PEND  = 8'h14;
  localparam logic [7:0]  A_CTRL  = 8'h18;
  localparam logic [7:0]  A_LOAD  = 8'h1C;
  localparam logic [7:0]  A_COUNT = 8'h20;
  localparam logic [7:0]  A_TRIG  = 8'h24;
  localparam logic [7:0]  A_DELAY = 8'h28;
  localparam logic [7:0]  A_KEY   = 8'h2C;
  localparam logic [31:0] EXP_REV = 32'h0002_0103;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refTick = 1'b0;
  logic        regRd = 1'b0;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        regReady;
  logic        irqOut;
  logic        resetReq;

  int nTests = 0;
  int nFail = 0;
  int rstReqSeen = 0;
  bit finished = 1'b0;

  keyedWatchdog dut (
    .clk     (clk),
    .rstN    (rstN),
    .refTick (refTick),
    .regRd   (regRd),
    .regWr   (regWr),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .regReady(regReady),
    .irqOut  (irqOut),
    .resetReq(resetReq)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (rstN && resetReq) rstReqSeen++;

  function automatic logic [31:0] expSteps(input int ticks, input bit preOn, input int ptv);
    return preOn ? 32'(ticks >> ptv) : 32'(ticks);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic rdy);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdata;
    rdy = regReady;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic rdy;
    rd(a, d, rdy);
    chk(req, d, exp);
  endtask

  task automatic waitPend();
    logic [31:0] d;
    logic rdy;
    for (int i = 0; i < 20; i++) begin
      rd(A_PEND, d, rdy);
      if (d == 32'd0) break;
    end
  endtask

  task automatic syncWr(input logic [7:0] a, input logic [31:0] d);
    wr(a, d);
    waitPend();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      refTick = 1'b1;
      @(negedge clk);
      refTick = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic rdy;
    void'($urandom(32'd20250117));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state, R13 revision and unmapped
    rdChk("R1 revision", A_REV, EXP_REV);
    rdChk("R1 counter", A_COUNT, 32'd0);
    rdChk("R1 load", A_LOAD, 32'd0);
    rdChk("R1 ctrl", A_CTRL, 32'd0);
    rdChk("R1 pend", A_PEND, 32'd0);
    rdChk("R1 status", A_STAT, 32'd0);
    chk("R1 irqOut", 32'(irqOut), 32'd0);
    regRd = 1'b1; regAddr = 8'h3C;
    @(negedge clk);
    regRd = 1'b0;
    chk("R13 unmapped", regRdata, 32'd0);
    chk("R13 ready after read", 32'(regReady), 32'd1);
    @(negedge clk);
    chk("R13 ready idle", 32'(regReady), 32'd0);

    // R2 pending latency on load
    wr(A_LOAD, 32'hFFFF_FFF0);
    for (int i = 0; i < 4; i++) rdChk("R2 pending held", A_PEND, 32'h2);
    rdChk("R2 pending cleared", A_PEND, 32'h0);
    rdChk("R2 load committed", A_LOAD, 32'hFFFF_FFF0);
    rdChk("R3 load write leaves counter", A_COUNT, 32'd0);

    // R8 trigger reload
    syncWr(A_TRIG, 32'd1);
    rdChk("R8 reload on new trigger", A_COUNT, 32'hFFFF_FFF0);

    // R3 halted counter holds
    ticks(3);
    rdChk("R3 halted holds", A_COUNT, 32'hFFFF_FFF0);

    // R7 lone and mismatched start keys
    syncWr(A_KEY, 32'h4444);
    ticks(1);
    rdChk("R7 lone second key", A_COUNT, 32'hFFFF_FFF0);
    syncWr(A_KEY, 32'hBBBB);
    syncWr(A_KEY, 32'h5555);
    syncWr(A_KEY, 32'h4444);
    ticks(1);
    rdChk("R7 abandoned start", A_COUNT, 32'hFFFF_FFF0);

    // R5 start
    syncWr(A_KEY, 32'hBBBB);
    syncWr(A_KEY, 32'h4444);
    ticks(5);
    rdChk("R5 running after start keys", A_COUNT, 32'hFFFF_FFF5);

    // R7 mismatched halt, R6 halt
    syncWr(A_KEY, 32'hAAAA);
    syncWr(A_KEY, 32'h1234);
    ticks(2);
    rdChk("R7 abandoned halt", A_COUNT, 32'hFFFF_FFF7);
    syncWr(A_KEY, 32'hAAAA);
    syncWr(A_KEY, 32'h5555);
    ticks(2);
    rdChk("R6 halted after halt keys", A_COUNT, 32'hFFFF_FFF7);

    // R8 equal trigger value has no effect
    syncWr(A_KEY, 32'hBBBB);
    syncWr(A_KEY, 32'h4444);
    ticks(1);
    syncWr(A_TRIG, 32'd1);
    rdChk("R8 same trigger ignored", A_COUNT, 32'hFFFF_FFF8);
    syncWr(A_TRIG, 32'd2);
    rdChk("R8 changed trigger reloads", A_COUNT, 32'hFFFF_FFF0);

    // R10 early warning, R11 enables and W1C
    wr(A_ENSET, 32'h1);
    syncWr(A_DELAY, 32'hFFFF_FFF4);
    ticks(4);
    rdChk("R10 delay status", A_STAT, 32'h2);
    chk("R11 masked delay", 32'(irqOut), 32'd0);
    wr(A_ENSET, 32'h2);
    chk("R11 enabled delay irq", 32'(irqOut), 32'd1);
    rdChk("R11 enable readback", A_ENSET, 32'h3);
    wr(A_STAT, 32'h2);
    rdChk("R11 W1C delay", A_STAT, 32'h0);
    chk("R11 irq after clear", 32'(irqOut), 32'd0);

    // R9 overflow
    ticks(11);
    rdChk("R9 at all-ones", A_COUNT, 32'hFFFF_FFFF);
    chk("R9 no early reset", 32'(rstReqSeen), 32'd0);
    ticks(1);
    chk("R9 single reset pulse", 32'(rstReqSeen), 32'd1);
    rdChk("R9 reload after wrap", A_COUNT, 32'hFFFF_FFF0);
    rdChk("R9 overflow status", A_STAT, 32'h1);
    chk("R11 overflow irq", 32'(irqOut), 32'd1);
    wr(A_ENCLR, 32'h1);
    chk("R11 enable cleared", 32'(irqOut), 32'd0);
    rdChk("R11 enclr readback", A_ENCLR, 32'h2);
    wr(A_STAT, 32'h1);
    rdChk("R11 W1C overflow", A_STAT, 32'h0);

    // R4 prescaler
    syncWr(A_CTRL, 32'hA);
    syncWr(A_TRIG, 32'd3);
    ticks(8);
    rdChk("R4 divide by four", A_COUNT, 32'hFFFF_FFF2);
    ticks(3);
    rdChk("R4 partial phase", A_COUNT, 32'hFFFF_FFF2);
    ticks(1);
    rdChk("R4 phase completes", A_COUNT, 32'hFFFF_FFF3);
    syncWr(A_CTRL, 32'h2);
    syncWr(A_TRIG, 32'd4);
    ticks(3);
    rdChk("R4 bypass", A_COUNT, 32'hFFFF_FFF3);

    // R12 soft reset
    wr(A_SYS, 32'h1);
    rdChk("R12 busy bit", A_SYS, 32'h1);
    rdChk("R12 self clear", A_SYS, 32'h0);
    rdChk("R12 load default", A_LOAD, 32'd0);
    rdChk("R12 ctrl default", A_CTRL, 32'd0);
    rdChk("R12 enable default", A_ENSET, 32'd0);
    ticks(2);
    rdChk("R12 halted and cleared", A_COUNT, 32'd0);

    // R3 R4 R8 random loads, prescales and tick counts
    syncWr(A_KEY, 32'hBBBB);
    syncWr(A_KEY, 32'h4444);
    for (int i = 0; i < 40; i++) begin
      logic [31:0] ld;
      int ptv;
      int n;
      bit preOn;
      ld    = 32'h8000_0000 | ($urandom() & 32'h7FFF_0000);
      ptv   = int'($urandom() % 4);
      preOn = 1'($urandom() % 2);
      n     = 1 + int'($urandom() % 100);
      syncWr(A_CTRL, {28'd0, preOn, 3'(ptv)});
      syncWr(A_LOAD, ld);
      syncWr(A_TRIG, 32'(100 + i));
      ticks(n);
      rdChk("R3 R4 random count", A_COUNT, ld + expSteps(n, preOn, ptv));
    end
    chk("R9 no stray reset", 32'(rstReqSeen), 32'd1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule